// File: doc/BRIEF.md
# Sampling Phase Tuning Controller

This block is a hardware sequencer that picks the receive sampling delay of a high-speed memory-card host. It forces a delay-line code, runs a calibration handshake with the delay line, and then asks for one tuning-block read. An external comparator answers with match, mismatch or timeout. The sequencer moves through the codes 0, 4, 8 and so on up to 124, giving 32 trials. It keeps the longest run of consecutive passing codes and then programs the centre of that run through one more calibration handshake.

Software or a higher-level controller pulses `start` with the configured card clock (in MHz) and the bus width. It then waits for the `done` pulse and reads `ok`, `err_code` and `final_code`. At low clock rates no tuning is needed, so the request returns success at once. Any failure drops the forced code, the tuning enable and the tuned-clock select, so the receiver samples with its fixed clock again. The tuning-read request uses valid/ready. `rd_req_valid` stays high, with `dl_code` held stable, until a cycle in which `rd_req_ready` is high, and the request is taken in that cycle. The read result has no back-pressure: it is a one-cycle `rd_rsp_valid` strobe, and the block samples it only while it waits for a result.

Top module: `phase_tune_ctrl`

## Requirements
- R1: When `card_clk_mhz` is 52 or lower, a start produces `done` with `ok`=1 and `err_code`=0, and no calibration or read is performed.
- R2: `bus_width` encodes 0=1-bit, 1=4-bit, 2=8-bit and 3=reserved. Width 1 gives `rd_len`=64 and width 2 gives `rd_len`=128. Widths 0 and 3 end with `err_code`=3 and `ok`=0, and no read is issued.
- R3: The sweep issues exactly 32 reads with codes 0,4,...,124 in order, each with `dl_force`=1 and the trial code on `dl_code`.
- R4: Each code is followed by a calibration request. `dl_cal_req` drops on the cycle after `dl_cal_ack` is seen, or after CAL_POLL_MAX cycles without an acknowledge.
- R5: A pass after a fail (or as the first trial) opens a window of length 1 at that code. A pass after a pass lengthens the window by one. A fail closes it.
- R6: The best window is replaced only by a strictly longer one, so of two windows of equal length the earlier one is kept.
- R7: On success the code best_start + 4*(best_len>>1) is programmed through a calibration handshake. It then appears on `dl_code` and `final_code`, with `sclk_sel`=1, `ok`=1 and `err_code`=0.
- R8: When no trial passes, the block ends with `err_code`=1 and `ok`=0, and `dl_force`, `dl_sw_tune` and `sclk_sel` are cleared.
- R9: A read result flagged as timeout stops the sweep at once. The block ends with `err_code`=2 and the same three enables cleared.
- R10: Once a sweep has begun, its end (success or failure) pulses `dp_rst` for one cycle, then `cmd_rst` for one cycle, then `done`.
- R11: `abort` or `power_off` returns the block to idle on the next clock, with `busy`, `dl_force`, `dl_sw_tune`, `sclk_sel`, `dl_cal_req` and `rd_req_valid` low and no `done` pulse. This holds even when a read result arrives in the same cycle.
- R12: `busy` is high from the cycle after `start` through the `done` cycle. `ok`, `err_code` and `final_code` hold their values until the next start.
- R13: While `rd_req_valid` is high and `rd_req_ready` is low, the request and `dl_code` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (taken in idle) |
| abort | input | 1 | Cancel the run and fall back to the fixed clock |
| power_off | input | 1 | Card power removed; same effect as abort |
| card_clk_mhz | input | MHZ_W | Configured card clock in MHz |
| bus_width | input | 2 | 0=1-bit, 1=4-bit, 2=8-bit, 3=reserved |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run succeeded |
| err_code | output | 2 | 0 none, 1 no window, 2 timeout, 3 bad width |
| final_code | output | CODE_W | Chosen delay code |
| dl_force | output | 1 | Delay-line force-value enable |
| dl_sw_tune | output | 1 | Software-tuning enable of the delay line |
| sclk_sel | output | 1 | Use the tuned sampling clock |
| dl_code | output | CODE_W | Forced delay code |
| dl_cal_req | output | 1 | Calibration request |
| dl_cal_ack | input | 1 | Calibration acknowledge |
| rd_req_valid | output | 1 | Tuning-read request valid |
| rd_req_ready | input | 1 | Tuning-read request accepted |
| rd_len | output | RDLEN_W | Tuning block size in bytes |
| rd_rsp_valid | input | 1 | Read result strobe |
| rd_rsp_match | input | 1 | Read data matched the pattern |
| rd_rsp_timeout | input | 1 | Read did not complete in time |
| dp_rst | output | 1 | Data-path reset pulse |
| cmd_rst | output | 1 | Command-path reset pulse |

## Verification
Two events can fall in the same cycle: the read result that updates the window and ends a trial, and an abort that tears the run down. The bench drives `abort` in the same cycle as a chosen `rd_rsp_valid`. One cycle later it requires idle, cleared enables and no `done`. Separately, random ready back-pressure meets the read request so that a stall and code stability coincide. A `power_off` also lands in the middle of a calibration handshake.

// File: rtl/phtune_pkg.sv
package phtune_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_SET, ST_CAL, ST_RREQ, ST_RWAIT,
    ST_NEXT, ST_RST_DP, ST_RST_CMD, ST_FINISH
  } tune_st_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NOWIN = 2'd1,
    ERR_TMO   = 2'd2,
    ERR_WIDTH = 2'd3
  } tune_err_e;

  localparam logic [1:0] BW_4BIT = 2'd1;
  localparam logic [1:0] BW_8BIT = 2'd2;

endpackage

// File: rtl/phtune_cal.sv
module phtune_cal #(
  parameter int POLL_MAX = 1000,
  localparam int CW = $clog2(POLL_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic go,
  input  logic ack,
  output logic req,
  output logic fin
);

  logic [CW-1:0] polls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      fin   <= 1'b0;
      polls <= '0;
    end else if (kill) begin
      req   <= 1'b0;
      fin   <= 1'b0;
      polls <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        req   <= 1'b1;
        polls <= '0;
      end else if (req) begin
        if (ack || polls == CW'(POLL_MAX - 1)) begin
          req <= 1'b0;
          fin <= 1'b1;
        end else begin
          polls <= polls + 1'b1;
        end
      end
    end
  end

  // R4: an acknowledge ends the request on the next edge
  a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !kill && !go) |=> !req);
  // R4: every drop of the request that is not a kill reports completion
  a_r4_fin_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req) && !$past(kill)) |-> fin);

endmodule

// File: rtl/phtune_win.sv
module phtune_win #(
  parameter int CODE_W = 7,
  parameter int LEN_W  = 6,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              pass,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] best_start,
  output logic [LEN_W-1:0]  best_len,
  output logic [CODE_W-1:0] center
);

  localparam int SW = CODE_W + LEN_W;

  logic              prev_pass;
  logic [CODE_W-1:0] cur_start, nx_start;
  logic [LEN_W-1:0]  cur_len, nx_len;
  logic [SW-1:0]     mid_sum;

  always_comb begin
    nx_start = cur_start;
    nx_len   = cur_len;
    if (pass) begin
      if (prev_pass) begin
        nx_len = cur_len + 1'b1;
      end else begin
        nx_start = code;
        nx_len   = LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pass  <= 1'b0;
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (clr) begin
      prev_pass  <= 1'b0;
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (upd) begin
      prev_pass <= pass;
      cur_start <= nx_start;
      cur_len   <= nx_len;
      if (nx_len > best_len) begin
        best_start <= nx_start;
        best_len   <= nx_len;
      end
    end
  end

  always_comb begin
    mid_sum = SW'(best_start) + SW'(STEP) * SW'(best_len >> 1);
    center  = mid_sum[CODE_W-1:0];
  end

  // R6: the best length never shrinks within a run
  a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_len >= $past(best_len));
  // R5: a pass after a fail opens a window of length one
  a_r5_fresh_window: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pass && !prev_pass && !clr) |=> cur_len == LEN_W'(1));

endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
  import phtune_pkg::*;
#(
  parameter int CODE_W       = 7,
  parameter int STEP         = 4,
  parameter int MAX_CODE     = 124,
  parameter int CAL_POLL_MAX = 1000,
  parameter int SKIP_MHZ     = 52,
  parameter int MHZ_W        = 9,
  parameter int BLK4_BYTES   = 64,
  parameter int BLK8_BYTES   = 128,
  parameter int RDLEN_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               power_off,
  input  logic [MHZ_W-1:0]   card_clk_mhz,
  input  logic [1:0]         bus_width,
  output logic               busy,
  output logic               done,
  output logic               ok,
  output logic [1:0]         err_code,
  output logic [CODE_W-1:0]  final_code,
  output logic               dl_force,
  output logic               dl_sw_tune,
  output logic               sclk_sel,
  output logic [CODE_W-1:0]  dl_code,
  output logic               dl_cal_req,
  input  logic               dl_cal_ack,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [RDLEN_W-1:0] rd_len,
  input  logic               rd_rsp_valid,
  input  logic               rd_rsp_match,
  input  logic               rd_rsp_timeout,
  output logic               dp_rst,
  output logic               cmd_rst
);

  localparam int TRIALS = MAX_CODE / STEP + 1;
  localparam int LEN_W  = $clog2(TRIALS + 1);

  tune_st_e          state, st_n;
  logic [CODE_W-1:0] trial;
  logic              final_phase;
  logic              kill, width_ok, last_trial;
  logic              fail, succ, skip;
  tune_err_e         fail_code;
  logic              cal_go, cal_fin;
  logic              win_clr, win_upd;
  logic [CODE_W-1:0] best_start, center;
  logic [LEN_W-1:0]  best_len;

  assign kill       = abort | power_off;
  assign width_ok   = (bus_width == BW_4BIT) || (bus_width == BW_8BIT);
  assign last_trial = (int'(trial) + STEP) > MAX_CODE;
  assign cal_go     = (state == ST_SET) && !kill;
  assign win_clr    = (state == ST_CHECK);
  assign win_upd    = (state == ST_RWAIT) && rd_rsp_valid && !rd_rsp_timeout && !kill;

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FINISH);
  assign rd_req_valid = (state == ST_RREQ);
  assign dp_rst       = (state == ST_RST_DP);
  assign cmd_rst      = (state == ST_RST_CMD);

  phtune_cal #(.POLL_MAX(CAL_POLL_MAX)) u_cal (
    .clk  (clk),
    .rst_n(rst_n),
    .kill (kill),
    .go   (cal_go),
    .ack  (dl_cal_ack),
    .req  (dl_cal_req),
    .fin  (cal_fin)
  );

  phtune_win #(.CODE_W(CODE_W), .LEN_W(LEN_W), .STEP(STEP)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (win_clr),
    .upd       (win_upd),
    .pass      (rd_rsp_match),
    .code      (dl_code),
    .best_start(best_start),
    .best_len  (best_len),
    .center    (center)
  );

  always_comb begin
    st_n      = state;
    fail      = 1'b0;
    fail_code = ERR_NONE;
    succ      = 1'b0;
    skip      = 1'b0;
    case (state)
      ST_IDLE:  if (start) st_n = ST_CHECK;
      ST_CHECK: begin
        if (card_clk_mhz <= MHZ_W'(SKIP_MHZ)) begin
          skip = 1'b1;
          st_n = ST_FINISH;
        end else if (!width_ok) begin
          fail      = 1'b1;
          fail_code = ERR_WIDTH;
          st_n      = ST_FINISH;
        end else begin
          st_n = ST_SET;
        end
      end
      ST_SET:   st_n = ST_CAL;
      ST_CAL: begin
        if (cal_fin) begin
          st_n = final_phase ? ST_RST_DP : ST_RREQ;
          succ = final_phase;
        end
      end
      ST_RREQ:  if (rd_req_ready) st_n = ST_RWAIT;
      ST_RWAIT: begin
        if (rd_rsp_valid) begin
          if (rd_rsp_timeout) begin
            fail      = 1'b1;
            fail_code = ERR_TMO;
            st_n      = ST_RST_DP;
          end else begin
            st_n = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (last_trial && best_len == '0) begin
          fail      = 1'b1;
          fail_code = ERR_NOWIN;
          st_n      = ST_RST_DP;
        end else begin
          st_n = ST_SET;
        end
      end
      ST_RST_DP:  st_n = ST_RST_CMD;
      ST_RST_CMD: st_n = ST_FINISH;
      ST_FINISH:  st_n = ST_IDLE;
      default:    st_n = ST_IDLE;
    endcase
    if (kill) begin
      st_n = ST_IDLE;
      fail = 1'b0;
      succ = 1'b0;
      skip = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      trial       <= '0;
      final_phase <= 1'b0;
      ok          <= 1'b0;
      err_code    <= ERR_NONE;
      final_code  <= '0;
      dl_force    <= 1'b0;
      dl_sw_tune  <= 1'b0;
      sclk_sel    <= 1'b0;
      dl_code     <= '0;
      rd_len      <= '0;
    end else begin
      state <= st_n;
      if (kill) begin
        dl_force   <= 1'b0;
        dl_sw_tune <= 1'b0;
        sclk_sel   <= 1'b0;
      end else begin
        if (state == ST_IDLE && start) begin
          ok         <= 1'b0;
          err_code   <= ERR_NONE;
          final_code <= '0;
        end
        if (state == ST_CHECK && st_n == ST_SET) begin
          dl_sw_tune  <= 1'b1;
          trial       <= '0;
          final_phase <= 1'b0;
          rd_len      <= (bus_width == BW_8BIT) ? RDLEN_W'(BLK8_BYTES)
                                                : RDLEN_W'(BLK4_BYTES);
        end
        if (skip) ok <= 1'b1;
        if (state == ST_SET) begin
          dl_code  <= trial;
          dl_force <= 1'b1;
        end
        if (state == ST_NEXT && !fail) begin
          if (last_trial) begin
            trial       <= center;
            final_phase <= 1'b1;
          end else begin
            trial <= CODE_W'(int'(trial) + STEP);
          end
        end
        if (succ) begin
          sclk_sel   <= 1'b1;
          ok         <= 1'b1;
          final_code <= dl_code;
        end
        if (fail) begin
          err_code   <= fail_code;
          ok         <= 1'b0;
          dl_force   <= 1'b0;
          dl_sw_tune <= 1'b0;
          sclk_sel   <= 1'b0;
        end
      end
    end
  end

  // R11: abort or power-off leaves everything idle and disabled one clock later
  a_r11_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !dl_force && !dl_sw_tune && !sclk_sel && !dl_cal_req && !rd_req_valid));
  // R13: a stalled read request keeps its code
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !kill) |=> (rd_req_valid && $stable(dl_code)));
  // R3: every read runs with a forced code and no calibration in flight
  a_r3_forced_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (dl_force && dl_sw_tune && !dl_cal_req));
  // R10: command-path reset always follows the data-path reset
  a_r10_reset_order: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |-> $past(dp_rst));
  // R7: a successful end carries no error code
  a_r7_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (err_code == 2'd0));

endmodule

// File: tb/test_phase_tune_ctrl.sv
`timescale 1ns/1ps
module test_phase_tune_ctrl;

  localparam int CAL_N = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, start, abort, power_off;
  logic [8:0] card_clk_mhz;
  logic [1:0] bus_width;
  logic       busy, done, ok, dl_force, dl_sw_tune, sclk_sel, dl_cal_req, dl_cal_ack;
  logic [1:0] err_code;
  logic [6:0] final_code, dl_code;
  logic       rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_match, rd_rsp_timeout;
  logic [7:0] rd_len;
  logic       dp_rst, cmd_rst;

  phase_tune_ctrl #(.CAL_POLL_MAX(CAL_N)) i_phase_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .power_off(power_off),
    .card_clk_mhz(card_clk_mhz), .bus_width(bus_width),
    .busy(busy), .done(done), .ok(ok), .err_code(err_code), .final_code(final_code),
    .dl_force(dl_force), .dl_sw_tune(dl_sw_tune), .sclk_sel(sclk_sel), .dl_code(dl_code),
    .dl_cal_req(dl_cal_req), .dl_cal_ack(dl_cal_ack),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_len(rd_len),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_match(rd_rsp_match), .rd_rsp_timeout(rd_rsp_timeout),
    .dp_rst(dp_rst), .cmd_rst(cmd_rst)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] pat;
  int to_idx = -1, ab_idx = -1, ack_dly = 0;
  bit ack_never = 0, ab_on_rsp = 0, ab_fired = 0, ab_clr = 0;
  int n_reads, n_cals, code_bad, cal_hi, max_cal, min_cal, n_dp, n_cmd, ord_bad, n_done;
  bit pend = 0, prev_dp = 0, done_busy = 0;
  int pidx = 0, lat = 0;

  task automatic chk(input bit c, input string req, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the window search: longest run, earliest on a tie
  function automatic int model_code(input logic [31:0] p, output bit found);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    for (int i = 0; i < 32; i++) begin
      if (p[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    found = (bl > 0);
    return 4 * bs + 4 * (bl / 2);
  endfunction

  always @(negedge clk) begin
    rd_rsp_valid = 1'b0; rd_rsp_match = 1'b0; rd_rsp_timeout = 1'b0;
    if (ab_clr) begin abort = 1'b0; ab_clr = 0; end
    if (pend) begin
      if (lat == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_match = pat[pidx];
        rd_rsp_timeout = (pidx == to_idx);
        pend = 0;
        if (ab_on_rsp && pidx == ab_idx) begin abort = 1'b1; ab_clr = 1; ab_fired = 1; end
      end else lat--;
    end
    rd_req_ready = ($urandom % 4) != 0;
    if (rd_req_valid && rd_req_ready) begin
      if (dl_code != 7'(4 * n_reads) || !dl_force) code_bad++;
      pidx = n_reads; n_reads++; pend = 1; lat = $urandom % 3;
    end
    if (dl_cal_req) begin
      cal_hi++;
      dl_cal_ack = !ack_never && (cal_hi > ack_dly);
    end else begin
      if (cal_hi > 0) begin
        n_cals++;
        if (cal_hi > max_cal) max_cal = cal_hi;
        if (cal_hi < min_cal) min_cal = cal_hi;
      end
      cal_hi = 0; dl_cal_ack = 1'b0;
    end
    if (cmd_rst && !prev_dp) ord_bad++;
    if (dp_rst) n_dp++;
    if (cmd_rst) n_cmd++;
    prev_dp = dp_rst;
    if (done) begin n_done++; done_busy = busy; end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic launch(input int mhz, input int bw, input logic [31:0] p);
    tick();
    pat = p; n_reads = 0; n_cals = 0; code_bad = 0; max_cal = 0; min_cal = 1 << 30;
    n_dp = 0; n_cmd = 0; ord_bad = 0; n_done = 0; pend = 0;
    card_clk_mhz = 9'(mhz); bus_width = 2'(bw); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run(input int mhz, input int bw, input logic [31:0] p);
    int k = 0;
    launch(mhz, bw, p);
    chk(busy == 1'b1, "R12 busy after start", busy, 1);
    while (n_done == 0 && k < 40000) begin tick(); k++; end
    chk(n_done == 1, "R12 done pulse seen", n_done, 1);
    chk(done_busy == 1'b1, "R12 busy in done cycle", done_busy, 1);
  endtask

  initial begin
    #(5ns * 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit found;
    int exp;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; start = 0; abort = 0; power_off = 0; card_clk_mhz = '0; bus_width = '0;
    dl_cal_ack = 0; rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_match = 0; rd_rsp_timeout = 0;
    pat = '0;
    repeat (3) tick();
    chk(busy == 0 && done == 0 && dl_force == 0 && dl_cal_req == 0 && rd_req_valid == 0,
        "R12 reset state quiet", busy, 0);
    rst_n = 1;
    tick();

    // R1 skip at and below 52 MHz
    run(52, 1, 32'hFFFF_FFFF);
    chk(ok == 1 && err_code == 0, "R1 skip ok", err_code, 0);
    chk(n_reads == 0 && n_cals == 0, "R1 no activity", n_reads + n_cals, 0);

    // R2 bad widths
    run(200, 0, 32'hFFFF_FFFF);
    chk(err_code == 3 && ok == 0, "R2 width 1-bit rejected", err_code, 3);
    chk(n_reads == 0, "R2 no read on bad width", n_reads, 0);
    run(200, 3, 32'hFFFF_FFFF);
    chk(err_code == 3, "R2 reserved width rejected", err_code, 3);

    // R3 R5 R7 R10 directed window, 8-bit
    ack_dly = 2;
    run(200, 2, 32'h0000_1FE0);
    chk(rd_len == 128, "R2 8-bit length", rd_len, 128);
    chk(n_reads == 32 && code_bad == 0, "R3 sweep codes", n_reads, 32);
    chk(n_cals == 33, "R4 handshake count", n_cals, 33);
    chk(ok == 1 && final_code == 36 && dl_code == 36, "R7 centre code", final_code, 36);
    chk(sclk_sel == 1 && dl_force == 1, "R7 tuned clock selected", sclk_sel, 1);
    chk(n_dp == 1 && n_cmd == 1 && ord_bad == 0, "R10 reset pulses", n_dp + n_cmd, 2);

    // R6 ties keep the earlier window
    run(300, 1, 32'hE000_1C1C);
    chk(final_code == 12, "R6 earlier of equal windows", final_code, 12);
    chk(rd_len == 64, "R2 4-bit length", rd_len, 64);

    // R5 edge windows
    run(200, 1, 32'hFFFF_FFFF);
    chk(final_code == 64, "R5 full window", final_code, 64);
    run(200, 1, 32'h8000_0000);
    chk(final_code == 124, "R5 last code only", final_code, 124);

    // R8 no window
    run(200, 2, 32'h0);
    chk(err_code == 1 && ok == 0, "R8 no window error", err_code, 1);
    chk(!dl_force && !dl_sw_tune && !sclk_sel, "R8 fallback", dl_force, 0);
    chk(n_reads == 32 && n_dp == 1 && ord_bad == 0, "R10 resets on failure", n_dp, 1);

    // R9 timeout
    to_idx = 7;
    run(200, 1, 32'hFFFF_FFFF);
    to_idx = -1;
    chk(err_code == 2 && n_reads == 8, "R9 timeout stops sweep", n_reads, 8);
    chk(!dl_force && !sclk_sel && !dl_sw_tune, "R9 fallback", dl_force, 0);

    // R4 no acknowledge: request held for the full poll budget
    ack_never = 1;
    run(200, 1, 32'h0000_00F0);
    ack_never = 0;
    chk(min_cal == CAL_N && max_cal == CAL_N, "R4 poll limit", max_cal, CAL_N);
    chk(final_code == 24, "R4 result after poll limit", final_code, 24);

    // R12 hold after done
    repeat (5) tick();
    chk(final_code == 24 && ok == 1 && !busy, "R12 outputs held", final_code, 24);

    // R11 abort in the same cycle as a read result
    ab_on_rsp = 1; ab_idx = 5; ab_fired = 0;
    launch(200, 1, 32'hFFFF_FFFF);
    for (int k = 0; k < 5000 && !ab_fired; k++) tick();
    tick();
    chk(!busy && !dl_force && !dl_sw_tune && !dl_cal_req && !rd_req_valid, "R11 abort idle", busy, 0);
    ab_on_rsp = 0;
    repeat (10) tick();
    chk(n_done == 0, "R11 no done after abort", n_done, 0);

    // R11 power-off during calibration
    launch(200, 2, 32'hFFFF_FFFF);
    for (int k = 0; k < 5000 && !dl_cal_req; k++) tick();
    power_off = 1'b1;
    tick();
    power_off = 1'b0;
    chk(!busy && !dl_cal_req && !dl_force, "R11 power-off idle", busy, 0);
    repeat (4) tick();

    // random patterns
    for (int it = 0; it < 12; it++) begin
      logic [31:0] p;
      int bw;
      p = $urandom | $urandom;
      if (it % 3 == 0) p = $urandom & $urandom & $urandom;
      if (it == 5) p = '0;
      bw = 1 + ($urandom % 2);
      ack_dly = $urandom % 4;
      run(100 + ($urandom % 100), bw, p);
      exp = model_code(p, found);
      if (found) chk(ok == 1 && final_code == 7'(exp), "R7 random centre", final_code, exp);
      else       chk(err_code == 1, "R8 random no window", err_code, 1);
      chk(code_bad == 0 && n_reads == 32, "R3 random sweep", code_bad, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule